// File: doc/BRIEF.md
# Load Value Predictor with Classification

This block guesses the result of a load while the load is still being fetched, and separately judges whether that guess is worth using. A value table keeps the most recent result seen for each slot, chosen by low bits of the load's program counter. A second table of saturating confidence counters, indexed the same way, sorts each load into one of three classes: do not use the guess, use the guess and check it, or treat the load as constant. A small fully associative tracker records the memory address of loads that reached the constant class. Only a load still held by the tracker is reported as constant, which lets the pipeline skip the cache check for it. Any snooped store to a tracked address revokes that status.

Lookups arrive on a valid/ready request channel and return one cycle later on a valid/ready response channel. Back-pressure is one level deep. A request is taken when `pq_valid` and `pq_ready` are both high. `pq_ready` is high whenever the response register is empty or is being drained in the same cycle. A response held while `pr_ready` is low keeps its value and class unchanged. Results of executed loads and store addresses arrive as plain one-cycle strobes. They are always accepted, because dropping a training result or a store would leave a wrong constant in the tracker.

Top module: `lvp_top`

## Requirements
- R1: A request is accepted when `pq_valid` and `pq_ready` are high at a clock edge, and its response appears with `pr_valid` high after that edge. `pq_ready` is high exactly when no response is held or `pr_ready` is high. While `pr_valid` is high and `pr_ready` is low, `pr_value` and `pr_class` stay stable and `pq_ready` is low.
- R2: The value table has no tags and is direct-mapped on `pc[7:2]` (64 slots by default). Every slot resets to zero. Loads whose PCs share those bits share one slot.
- R3: A verify strobe compares `vf_value` with the stored slot value. On a mismatch the slot is overwritten. After any verify, the slot holds `vf_value`.
- R4: Each slot of the confidence table is a saturating counter that resets to 0, steps up on a correct verify and steps down on a wrong one. It saturates at 0 and at its maximum (3 for 2-bit counters). The confidence table is indexed by the same PC bits as the value table.
- R5: In 2-bit mode, `pr_class` is 0 (do not use) for counts 0 and 1, and 1 (use and check) for count 2. For count 3 it is 2 (constant) if the tracker holds the request's full PC, and 1 otherwise. The value 3 is never produced.
- R6: In 1-bit mode (`CNT_W`=1), count 0 gives class 0. Count 1 gives class 2 if the tracker holds the PC, and class 1 otherwise.
- R7: The tracker stores a {full PC, address} pair when a verify is correct and leaves the counter at its maximum. A PC that is already held has its address updated in place, so no PC is held twice. A PC that merely aliases a tracked one in the tables is not treated as constant.
- R8: A store strobe whose address equals a tracked address clears that entry. A store to any other address changes nothing. A store to the same address as a fill in the same cycle prevents the fill.
- R9: A verify or store changes no table slot other than the one indexed by its own PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pq_valid | input | 1 | Prediction request valid |
| pq_ready | output | 1 | Prediction request can be taken |
| pq_pc | input | PC_W | PC of the load being fetched |
| pr_valid | output | 1 | Prediction response valid |
| pr_ready | input | 1 | Consumer takes the response |
| pr_value | output | DATA_W | Predicted load value |
| pr_class | output | 2 | 0 do not use, 1 use and check, 2 constant |
| vf_valid | input | 1 | Executed load result strobe |
| vf_pc | input | PC_W | PC of the executed load |
| vf_addr | input | ADDR_W | Memory address the load read |
| vf_value | input | DATA_W | Actual loaded value |
| st_valid | input | 1 | Store address snoop strobe |
| st_addr | input | ADDR_W | Address written by the store |

## Verification
The bench drives each counter to both ends of its range. A counter that wraps would drop a constant load to class 0 after one more correct result, or jump to constant after a wrong result at zero. It checks that a store revokes constant status only on an exact address match, and that a fill and a matching store in the same cycle leave no entry, since a fill that wins would let a load skip the cache after its data changed. It also checks that aliased PCs share the value and counter slots but not the constant entry, and that a response stalled by back-pressure is neither overwritten nor lost.

// File: rtl/lvp_pkg.sv
package lvp_pkg;
  typedef enum logic [1:0] {
    LC_SKIP  = 2'd0,
    LC_USE   = 2'd1,
    LC_CONST = 2'd2
  } lclass_e;
endpackage

// File: rtl/lvp_value_tbl.sv
module lvp_value_tbl #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [DATA_W-1:0] lk_data,
  input  logic              vf_valid,
  input  logic [IDX_W-1:0]  vf_idx,
  input  logic [DATA_W-1:0] vf_data,
  output logic              vf_match
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  assign lk_data  = mem_q[lk_idx];
  assign vf_match = (mem_q[vf_idx] == vf_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (vf_valid && !vf_match) begin
      mem_q[vf_idx] <= vf_data;
    end
  end

  AST_VT_LAST_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    vf_valid |=> mem_q[$past(vf_idx)] == $past(vf_data)); // R3
endmodule

// File: rtl/lvp_class_tbl.sv
module lvp_class_tbl #(
  parameter int CNT_W = 2,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_top,
  output logic             lk_use,
  input  logic             vf_valid,
  input  logic [IDX_W-1:0] vf_idx,
  input  logic             vf_ok,
  output logic             vf_sat
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt_q [DEPTH];
  logic [CNT_W-1:0] cur, nxt, lk_cnt;

  assign lk_cnt = cnt_q[lk_idx];
  assign lk_top = (lk_cnt == CMAX);

  generate
    if (CNT_W == 1) begin : g_one_bit
      assign lk_use = 1'b0;
    end else begin : g_multi_bit
      assign lk_use = (lk_cnt == CMAX - 1'b1);
    end
  endgenerate

  always_comb begin
    cur = cnt_q[vf_idx];
    if (vf_ok) nxt = (cur == CMAX) ? cur : cur + 1'b1;
    else       nxt = (cur == '0)   ? cur : cur - 1'b1;
  end
  assign vf_sat = (nxt == CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= '0;
    end else if (vf_valid) begin
      cnt_q[vf_idx] <= nxt;
    end
  end

  AST_CNT_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (vf_valid && vf_ok && cnt_q[vf_idx] == CMAX) |=> cnt_q[$past(vf_idx)] == CMAX); // R4
  AST_CNT_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (vf_valid && !vf_ok && cnt_q[vf_idx] == '0) |=> cnt_q[$past(vf_idx)] == '0); // R4
endmodule

// File: rtl/lvp_const_trk.sv
module lvp_const_trk #(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32,
  parameter int N      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_hit,
  input  logic              fill_en,
  input  logic [PC_W-1:0]   fill_pc,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr
);
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]      v_q;
  logic [PC_W-1:0]   pc_q [N];
  logic [ADDR_W-1:0] ad_q [N];
  logic [PTR_W-1:0]  rr_q;
  logic [N-1:0]      lk_m, fl_m, snp_m;
  logic [PTR_W-1:0]  tgt;
  logic              found, do_fill;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign lk_m[g]  = v_q[g] && (pc_q[g] == lk_pc);
    assign fl_m[g]  = v_q[g] && (pc_q[g] == fill_pc);
    assign snp_m[g] = snp_valid && v_q[g] && (ad_q[g] == snp_addr);
  end
  assign lk_hit  = |lk_m;
  assign do_fill = fill_en && !(snp_valid && snp_addr == fill_addr);

  always_comb begin
    tgt   = rr_q;
    found = 1'b0;
    for (int i = 0; i < N; i++)
      if (!found && fl_m[i]) begin tgt = PTR_W'(i); found = 1'b1; end
    for (int i = 0; i < N; i++)
      if (!found && !v_q[i]) begin tgt = PTR_W'(i); found = 1'b1; end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= '0;
      rr_q <= '0;
      for (int i = 0; i < N; i++) begin pc_q[i] <= '0; ad_q[i] <= '0; end
    end else begin
      for (int i = 0; i < N; i++) if (snp_m[i]) v_q[i] <= 1'b0;
      if (do_fill) begin
        v_q[tgt]  <= 1'b1;
        pc_q[tgt] <= fill_pc;
        ad_q[tgt] <= fill_addr;
        if (!found) rr_q <= (rr_q == PTR_W'(N - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  // checker state: last snooped address must be gone from every live entry
  logic              chk_d_q;
  logic [ADDR_W-1:0] chk_a_q;
  logic [N-1:0]      chk_m;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin chk_d_q <= 1'b0; chk_a_q <= '0; end
    else begin chk_d_q <= snp_valid; chk_a_q <= snp_addr; end
  end
  for (genvar g = 0; g < N; g++) begin : g_chk
    assign chk_m[g] = v_q[g] && (ad_q[g] == chk_a_q);
  end

  AST_SNOOP_REVOKE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_d_q |-> chk_m == '0); // R8
  AST_PC_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_m)); // R7
endmodule

// File: rtl/lvp_top.sv
module lvp_top #(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  parameter int PC_LSB = 2,
  parameter int CNT_W  = 2,
  parameter int TRK_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pq_valid,
  output logic              pq_ready,
  input  logic [PC_W-1:0]   pq_pc,
  output logic              pr_valid,
  input  logic              pr_ready,
  output logic [DATA_W-1:0] pr_value,
  output logic [1:0]        pr_class,
  input  logic              vf_valid,
  input  logic [PC_W-1:0]   vf_pc,
  input  logic [ADDR_W-1:0] vf_addr,
  input  logic [DATA_W-1:0] vf_value,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr
);
  import lvp_pkg::*;

  logic [IDX_W-1:0]  lk_idx, vf_idx;
  logic [DATA_W-1:0] lk_data;
  logic              vf_match, vf_sat, lk_top, lk_use, trk_hit, accept;
  lclass_e           cls;
  logic              pr_valid_q;
  logic [DATA_W-1:0] pr_value_q;
  lclass_e           pr_class_q;

  assign lk_idx = pq_pc[PC_LSB +: IDX_W];
  assign vf_idx = vf_pc[PC_LSB +: IDX_W];

  lvp_value_tbl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_vt (
    .clk(clk), .rst_n(rst_n), .lk_idx(lk_idx), .lk_data(lk_data),
    .vf_valid(vf_valid), .vf_idx(vf_idx), .vf_data(vf_value), .vf_match(vf_match));

  lvp_class_tbl #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_ct (
    .clk(clk), .rst_n(rst_n), .lk_idx(lk_idx), .lk_top(lk_top), .lk_use(lk_use),
    .vf_valid(vf_valid), .vf_idx(vf_idx), .vf_ok(vf_match), .vf_sat(vf_sat));

  lvp_const_trk #(.PC_W(PC_W), .ADDR_W(ADDR_W), .N(TRK_N)) u_trk (
    .clk(clk), .rst_n(rst_n), .lk_pc(pq_pc), .lk_hit(trk_hit),
    .fill_en(vf_valid && vf_match && vf_sat), .fill_pc(vf_pc), .fill_addr(vf_addr),
    .snp_valid(st_valid), .snp_addr(st_addr));

  always_comb begin
    if (lk_top)      cls = trk_hit ? LC_CONST : LC_USE;
    else if (lk_use) cls = LC_USE;
    else             cls = LC_SKIP;
  end

  assign pq_ready = !pr_valid_q || pr_ready;
  assign accept   = pq_valid && pq_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr_valid_q <= 1'b0;
      pr_value_q <= '0;
      pr_class_q <= LC_SKIP;
    end else if (accept) begin
      pr_valid_q <= 1'b1;
      pr_value_q <= lk_data;
      pr_class_q <= cls;
    end else if (pr_ready) begin
      pr_valid_q <= 1'b0;
    end
  end

  assign pr_valid = pr_valid_q;
  assign pr_value = pr_value_q;
  assign pr_class = pr_class_q;

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_valid && !pr_ready) |=> pr_valid && $stable(pr_value) && $stable(pr_class)); // R1
  AST_ACCEPT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (pq_valid && pq_ready) |=> pr_valid); // R1
  AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pr_valid |-> pr_class != 2'd3); // R5
endmodule

// File: tb/tb_lvp_top.sv
module tb_lvp_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pq_valid = 1'b0, pr_ready = 1'b1;
  logic [31:0] pq_pc = '0;
  logic        vf_valid = 1'b0, st_valid = 1'b0;
  logic [31:0] vf_pc = '0, vf_addr = '0, vf_value = '0, st_addr = '0;
  logic        pq_ready, pr_valid, pq_ready1, pr_valid1;
  logic [31:0] pr_value, pr_value1;
  logic [1:0]  pr_class, pr_class1;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  lvp_top dut (.clk(clk), .rst_n(rst_n), .pq_valid(pq_valid), .pq_ready(pq_ready), .pq_pc(pq_pc),
    .pr_valid(pr_valid), .pr_ready(pr_ready), .pr_value(pr_value), .pr_class(pr_class),
    .vf_valid(vf_valid), .vf_pc(vf_pc), .vf_addr(vf_addr), .vf_value(vf_value),
    .st_valid(st_valid), .st_addr(st_addr));

  lvp_top #(.CNT_W(1)) dut_one (.clk(clk), .rst_n(rst_n), .pq_valid(pq_valid), .pq_ready(pq_ready1),
    .pq_pc(pq_pc), .pr_valid(pr_valid1), .pr_ready(pr_ready), .pr_value(pr_value1),
    .pr_class(pr_class1), .vf_valid(vf_valid), .vf_pc(vf_pc), .vf_addr(vf_addr),
    .vf_value(vf_value), .st_valid(st_valid), .st_addr(st_addr));

  localparam logic [31:0] PA = 32'h104, PB = 32'h204, PC = 32'h108, PD = 32'h10C, PX = 32'h300;
  localparam int NV = 28;
  // op: 0 predict, 1 verify, 2 store snoop
  localparam logic [1:0] V_OP [NV] = '{0,1,0,1,0,1,0,1,0,1,0,2,0,2,0,1,0,0,1,0,0,1,0,0,1,0,1,0};
  localparam logic [31:0] V_PC [NV] = '{PA,PA,PA,PA,PA,PA,PA,PA,PA,PA,PA,0,PA,0,PA,PA,PA,PC,
                                        PB,PA,PB,PA,PA,PB,PA,PA,PA,PA};
  localparam logic [31:0] V_AD [NV] = '{0,32'h4000,0,32'h4000,0,32'h4000,0,32'h4000,0,32'h4000,0,
                                        32'h5000,0,32'h4000,0,32'h4000,0,0,32'h4100,0,0,32'h4000,
                                        0,0,32'h4000,0,32'h4000,0};
  localparam logic [31:0] V_VAL [NV] = '{0,7,7,7,7,7,7,7,7,7,7,0,7,0,7,7,7,0,9,9,9,9,9,9,5,5,6,6};
  localparam logic [1:0] V_CLS [NV] = '{0,0,0,0,0,0,1,0,2,0,2,0,2,0,1,0,2,0,0,1,1,0,2,1,0,1,0,0};
  // requirement named by each predict row: R2 reset, R4 low saturation, R5 classes, R7 fill,
  // R4 high saturation, R8 miss/revoke, R9 untouched slot, R2 alias, R7 full-PC key, R3 overwrite
  localparam int V_RQ [NV] = '{2,0,4,0,5,0,5,0,7,0,4,0,8,0,8,0,7,9,0,2,2,0,7,7,0,3,0,4};

  task automatic chk(input string rq, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic strobe(input logic v, input logic [31:0] pc, input logic [31:0] ad,
                        input logic [31:0] val, input logic s, input logic [31:0] sa);
    @(negedge clk);
    vf_valid = v; vf_pc = pc; vf_addr = ad; vf_value = val; st_valid = s; st_addr = sa;
    @(negedge clk);
    vf_valid = 1'b0; st_valid = 1'b0;
  endtask

  task automatic predict(input string rq, input bit one, input logic [31:0] pc,
                         input logic [1:0] ecls, input logic [31:0] eval);
    @(negedge clk);
    pq_valid = 1'b1; pq_pc = pc;
    @(negedge clk);
    pq_valid = 1'b0;
    if (one) chk(rq, pr_valid1 && pr_class1 == ecls && pr_value1 == eval,
                 {pr_valid1, 29'd0, pr_class1} ^ pr_value1, {1'b1, 29'd0, ecls} ^ eval);
    else     chk(rq, pr_valid && pr_class == ecls && pr_value == eval,
                 {pr_valid, 29'd0, pr_class} ^ pr_value, {1'b1, 29'd0, ecls} ^ eval);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", !pr_valid && pq_ready, {31'd0, pr_valid}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      case (V_OP[k])
        2'd0: predict($sformatf("R%0d vector %0d", V_RQ[k], k), 1'b0, V_PC[k], V_CLS[k], V_VAL[k]);
        2'd1: strobe(1'b1, V_PC[k], V_AD[k], V_VAL[k], 1'b0, 0);
        default: strobe(1'b0, 0, 0, 0, 1'b1, V_AD[k]);
      endcase
    end

    // R1 back-pressure: A holds class 0 value 6, C holds class 0 value 0
    @(negedge clk);
    pr_ready = 1'b0; pq_valid = 1'b1; pq_pc = PA;
    @(negedge clk);
    chk("R1 stall first", pr_valid && !pq_ready && pr_value == 32'd6, pr_value, 32'd6);
    pq_pc = PC;
    @(negedge clk);
    chk("R1 stall hold", pr_valid && !pq_ready && pr_value == 32'd6 && pr_class == 2'd0,
        pr_value, 32'd6);
    pr_ready = 1'b1;
    @(negedge clk);
    pq_valid = 1'b0;
    chk("R1 drain and take", pr_valid && pr_value == 32'd0, pr_value, 32'd0);

    // R8 fill and matching store in one cycle: no entry is kept
    strobe(1'b1, PD, 32'h7000, 32'd4, 1'b0, 0);
    strobe(1'b1, PD, 32'h7000, 32'd4, 1'b0, 0);
    strobe(1'b1, PD, 32'h7000, 32'd4, 1'b0, 0);
    strobe(1'b1, PD, 32'h7000, 32'd4, 1'b1, 32'h7000);
    predict("R8 fill blocked", 1'b0, PD, 2'd1, 32'd4);
    strobe(1'b1, PD, 32'h7000, 32'd4, 1'b0, 0);
    predict("R7 later fill", 1'b0, PD, 2'd2, 32'd4);

    // R6 one-bit counters
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    strobe(1'b1, PX, 32'h6000, 32'd3, 1'b0, 0);
    predict("R6 count 0", 1'b1, PX, 2'd0, 32'd3);
    strobe(1'b1, PX, 32'h6000, 32'd3, 1'b0, 0);
    predict("R6 constant", 1'b1, PX, 2'd2, 32'd3);
    strobe(1'b0, 0, 0, 0, 1'b1, 32'h6000);
    predict("R6 revoked", 1'b1, PX, 2'd1, 32'd3);
    strobe(1'b1, PX, 32'h6000, 32'd8, 1'b0, 0);
    predict("R6 mispredict", 1'b1, PX, 2'd0, 32'd8);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule